// File: doc/BRIEF.md
# Integer Decode and Execute Unit

This block is the combinational heart of a small load/store processor's execute stage. It accepts one 32-bit instruction word together with the two register values already read for it. The first value belongs to the register named in bits 25:21 and the second to the register named in bits 20:16. From these it produces the value to be written back, the index of the register that receives it, a write strobe, and a flag for instruction words it does not implement.

The opcode sits in bits 31:26. An opcode of zero selects a register-register form, whose operation comes from bits 5:0. The destination of that form is in bits 15:11, and any shift amount is in bits 10:6. Any other implemented opcode selects an immediate form. That form reads a 16-bit constant from bits 15:0 and writes the register named in bits 20:16. Whether the constant is sign- or zero-extended depends on the opcode.

Loads, stores, branches and jumps are not handled here. They report as unimplemented, so the surrounding pipeline must route them elsewhere before this unit's strobe is used. The register file is expected to drop any write aimed at register 0.

Top module: `riscDecodeExec`

## Requirements
- R1: The destination index is bits 15:11 of the instruction for opcode 0x00 and bits 20:16 for opcodes 0x09, 0x0C, 0x0D and 0x0F.
- R2: With opcode 0x00, function 0x21 gives first operand plus second operand, and function 0x23 gives first minus second, both modulo 2^32 with no overflow indication.
- R3: With opcode 0x00, function 0x25 gives bitwise OR, 0x26 gives XOR and 0x27 gives NOR of the two operands.
- R4: With opcode 0x00, function 0x00 shifts the second operand left, 0x02 shifts it right with zero fill, and 0x03 shifts it right with sign fill. In all three the distance is bits 10:6, and neither the first operand nor bits 25:21 affect the result.
- R5: Opcode 0x09 adds the first operand to bits 15:0 sign-extended to 32 bits.
- R6: Opcode 0x0C ANDs and opcode 0x0D ORs the first operand with bits 15:0 zero-extended to 32 bits.
- R7: Opcode 0x0F returns bits 15:0 in result bits 31:16 with zeros below, regardless of the first operand.
- R8: Any other opcode, or opcode 0x00 with any other function code, gives writeEn 0, illegalInstr 1 and result 0.
- R9: A destination of register 0 is still reported on destIdx with writeEn 1.
- R10: writeEn and illegalInstr are always complements of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word being executed |
| opA | input | 32 | Value of the register named in bits 25:21 |
| opB | input | 32 | Value of the register named in bits 20:16 |
| result | output | 32 | Value to write back |
| destIdx | output | 5 | Register index to write |
| writeEn | output | 1 | Write-back strobe for an implemented instruction |
| illegalInstr | output | 1 | Instruction word not implemented |

## Verification
All four outputs are purely combinational, so every result is due in the same cycle as its stimulus. No register stands between the inputs and the outputs. The bench changes the inputs on the falling clock edge and samples a quarter period later, before the next rising edge, so each sample sees settled logic. The assertions are immediate checks that are re-evaluated whenever an input changes, and they are skipped while any input is unknown.

// File: rtl/riscDecPkg.sv
package riscDecPkg;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int FUNC_W  = 6;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
  } aluOp_e;

  typedef struct packed {
    aluOp_e aluOp;
    logic   useImm;
    logic   immSign;
    logic   destRt;
    logic   legal;
  } ctrlStrobes_t;

  localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'h09;
  localparam logic [OP_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OP_W-1:0] OPC_UPPER = 6'h0F;

  localparam logic [FUNC_W-1:0] FN_SLL = 6'h00;
  localparam logic [FUNC_W-1:0] FN_SRL = 6'h02;
  localparam logic [FUNC_W-1:0] FN_SRA = 6'h03;
  localparam logic [FUNC_W-1:0] FN_ADD = 6'h21;
  localparam logic [FUNC_W-1:0] FN_SUB = 6'h23;
  localparam logic [FUNC_W-1:0] FN_OR  = 6'h25;
  localparam logic [FUNC_W-1:0] FN_XOR = 6'h26;
  localparam logic [FUNC_W-1:0] FN_NOR = 6'h27;
endpackage

// File: rtl/riscDecCtrl.sv
module riscDecCtrl
  import riscDecPkg::*;
(
  input  logic [OP_W-1:0]   opcode,
  input  logic [FUNC_W-1:0] funcCode,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes = '{aluOp: ALU_ADD, useImm: 1'b0, immSign: 1'b0, destRt: 1'b0, legal: 1'b1};
    unique case (opcode)
      OPC_REG: begin
        unique case (funcCode)
          FN_ADD:  strobes.aluOp = ALU_ADD;
          FN_SUB:  strobes.aluOp = ALU_SUB;
          FN_OR:   strobes.aluOp = ALU_OR;
          FN_XOR:  strobes.aluOp = ALU_XOR;
          FN_NOR:  strobes.aluOp = ALU_NOR;
          FN_SLL:  strobes.aluOp = ALU_SLL;
          FN_SRL:  strobes.aluOp = ALU_SRL;
          FN_SRA:  strobes.aluOp = ALU_SRA;
          default: strobes.legal = 1'b0;
        endcase
      end
      OPC_ADDI: begin
        strobes.aluOp   = ALU_ADD;
        strobes.useImm  = 1'b1;
        strobes.immSign = 1'b1;
        strobes.destRt  = 1'b1;
      end
      OPC_ANDI: begin
        strobes.aluOp  = ALU_AND;
        strobes.useImm = 1'b1;
        strobes.destRt = 1'b1;
      end
      OPC_ORI: begin
        strobes.aluOp  = ALU_OR;
        strobes.useImm = 1'b1;
        strobes.destRt = 1'b1;
      end
      OPC_UPPER: begin
        strobes.aluOp  = ALU_LUI;
        strobes.useImm = 1'b1;
        strobes.destRt = 1'b1;
      end
      default: strobes.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/riscDecDatapath.sv
module riscDecDatapath
  import riscDecPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = 5,
  parameter int IDX_W   = 5
) (
  input  ctrlStrobes_t       strobes,
  input  logic [IMM_W-1:0]   immField,
  input  logic [SHAMT_W-1:0] shamtField,
  input  logic [IDX_W-1:0]   rtField,
  input  logic [IDX_W-1:0]   rdField,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  output logic [DATA_W-1:0]  result,
  output logic [IDX_W-1:0]   destIdx
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] extImm;
  logic [DATA_W-1:0] srcB;
  logic [DATA_W-1:0] aluOut;

  assign extImm = {{EXT_W{immField[IMM_W-1] & strobes.immSign}}, immField};
  assign srcB   = strobes.useImm ? extImm : opB;

  always_comb begin
    unique case (strobes.aluOp)
      ALU_ADD: aluOut = opA + srcB;
      ALU_SUB: aluOut = opA - srcB;
      ALU_AND: aluOut = opA & srcB;
      ALU_OR:  aluOut = opA | srcB;
      ALU_XOR: aluOut = opA ^ srcB;
      ALU_NOR: aluOut = ~(opA | srcB);
      ALU_SLL: aluOut = opB << shamtField;
      ALU_SRL: aluOut = opB >> shamtField;
      ALU_SRA: aluOut = $unsigned($signed(opB) >>> shamtField);
      ALU_LUI: aluOut = {immField, {EXT_W{1'b0}}};
      default: aluOut = '0;
    endcase
  end

  assign result  = strobes.legal ? aluOut : '0;
  assign destIdx = strobes.destRt ? rtField : rdField;
endmodule

// File: rtl/riscDecodeExec.sv
module riscDecodeExec
  import riscDecPkg::*;
(
  input  logic [31:0] instrWord,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic [31:0] result,
  output logic [4:0]  destIdx,
  output logic        writeEn,
  output logic        illegalInstr
);
  ctrlStrobes_t strobes;

  riscDecCtrl uCtrl (
    .opcode   (instrWord[31:26]),
    .funcCode (instrWord[5:0]),
    .strobes  (strobes)
  );

  riscDecDatapath #(
    .DATA_W(32), .IMM_W(16), .SHAMT_W(5), .IDX_W(5)
  ) uDp (
    .strobes    (strobes),
    .immField   (instrWord[15:0]),
    .shamtField (instrWord[10:6]),
    .rtField    (instrWord[20:16]),
    .rdField    (instrWord[15:11]),
    .opA        (opA),
    .opB        (opB),
    .result     (result),
    .destIdx    (destIdx)
  );

  assign writeEn      = strobes.legal;
  assign illegalInstr = ~strobes.legal;
endmodule

// File: rtl/riscDecodeExecChk.sv
module riscDecodeExecChk (
  input logic [31:0] instrWord,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [31:0] result,
  input logic [4:0]  destIdx,
  input logic        writeEn,
  input logic        illegalInstr
);
  always_comb begin
    if (!$isunknown({instrWord, opA, opB})) begin
      // R10
      strobe_excl_chk: assert (writeEn != illegalInstr);
      // R8
      if (illegalInstr) illegal_zero_chk: assert (result == 32'h0);
      // R1
      if (writeEn && instrWord[31:26] == 6'h00) reg_dest_chk: assert (destIdx == instrWord[15:11]);
      // R1
      if (writeEn && instrWord[31:26] != 6'h00) imm_dest_chk: assert (destIdx == instrWord[20:16]);
      // R5
      if (instrWord[31:26] == 6'h09)
        addi_sext_chk: assert (result == opA + {{16{instrWord[15]}}, instrWord[15:0]});
      // R7
      if (instrWord[31:26] == 6'h0F)
        upper_fill_chk: assert (result == {instrWord[15:0], 16'h0000});
    end
  end
endmodule

bind riscDecodeExec riscDecodeExecChk uChk (.*);

// File: tb/riscDecodeExec_bench.sv
module riscDecodeExec_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] instrWord, opA, opB, result;
  logic [4:0]  destIdx;
  logic        writeEn, illegalInstr;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  riscDecodeExec u_riscDecodeExec (
    .instrWord(instrWord), .opA(opA), .opB(opB), .result(result),
    .destIdx(destIdx), .writeEn(writeEn), .illegalInstr(illegalInstr)
  );

  localparam int NV = 21;
  localparam logic [31:0] V_INS [NV] = '{
    32'h00221821, 32'h00222023, 32'h00222825, 32'h00223026, 32'h00223827,
    32'h00024100, 32'h00024902, 32'h00025103, 32'h000257C3, 32'h2425FFFF,
    32'h24257FFF, 32'h30268F0F, 32'h34278000, 32'h3C68DEAD, 32'h00220021,
    32'h24200001, 32'h8C220004, 32'h00221820, 32'h10220003, 32'h08000010,
    32'h00200008};
  localparam logic [31:0] V_A [NV] = '{
    32'hFFFFFFFF, 32'd5, 32'hF0F00000, 32'hFF00FF00, 32'h0000FFFF,
    32'h0000DEAD, 32'h0000DEAD, 32'h0000DEAD, 32'h0000DEAD, 32'd10,
    32'd1, 32'hFFFFFFFF, 32'h12340001, 32'h55555555, 32'd3,
    32'd1, 32'd8, 32'd8, 32'd8, 32'd8, 32'd8};
  localparam logic [31:0] V_B [NV] = '{
    32'd2, 32'd7, 32'h0000F0F0, 32'h0FF00FF0, 32'h00FF0000,
    32'h80000001, 32'h80000010, 32'h80000010, 32'h80000000, 32'd0,
    32'd0, 32'd0, 32'd0, 32'd0, 32'd4,
    32'd0, 32'd9, 32'd9, 32'd9, 32'd9, 32'd9};
  localparam logic [31:0] V_RES [NV] = '{
    32'd1, 32'hFFFFFFFE, 32'hF0F0F0F0, 32'hF0F0F0F0, 32'hFF000000,
    32'h00000010, 32'h08000001, 32'hF8000001, 32'hFFFFFFFF, 32'd9,
    32'h00008000, 32'h00008F0F, 32'h12348001, 32'hDEAD0000, 32'd7,
    32'd2, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0};
  localparam logic [4:0] V_DST [NV] = '{
    5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd10, 5'd5,
    5'd5, 5'd6, 5'd7, 5'd8, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0};
  localparam logic V_WEN [NV] = '{
    1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam string V_TAG [NV] = '{
    "R2", "R2", "R3", "R3", "R3", "R4", "R4", "R4", "R4", "R5",
    "R5", "R6", "R6", "R7", "R9", "R9", "R8", "R8", "R8", "R8", "R8"};

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instrWord = ins; opA = a; opB = b;
    #5;
  endtask

  task automatic expectAll(input string tag, input logic [31:0] res, input logic [4:0] dst, input logic wen);
    check(tag, "result", result, res);
    check("R10", "writeEn", {31'b0, writeEn}, {31'b0, wen});
    check("R10", "illegalInstr", {31'b0, illegalInstr}, {31'b0, ~wen});
    if (wen) check("R1", "destIdx", {27'b0, destIdx}, {27'b0, dst});
  endtask

  initial begin
    instrWord = 32'h0; opA = 32'h0; opB = 32'h0;
    repeat (3) @(posedge clk);
    #5;
    // R4 idle word 0 is a zero-distance left shift of zero into register 0
    expectAll("R4", 32'h0, 5'd0, 1'b1);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(V_INS[i], V_A[i], V_B[i]);
      expectAll(V_TAG[i], V_RES[i], V_DST[i], V_WEN[i]);
    end

    // R4 zero shift distance passes operand through; rs field and opA ignored
    apply(32'h03E25000, 32'hFFFFFFFF, 32'h13572468);
    expectAll("R4", 32'h13572468, 5'd10, 1'b1);
    // R4 logical right by 31 keeps only the top bit
    apply(32'h000257C2, 32'h0, 32'h80000000);
    expectAll("R4", 32'h00000001, 5'd10, 1'b1);
    // R2 subtraction wrap at zero minus one
    apply(32'h00222023, 32'h0, 32'h1);
    expectAll("R2", 32'hFFFFFFFF, 5'd4, 1'b1);
    // R5 most negative immediate
    apply(32'h24258000, 32'h00000000, 32'h0);
    expectAll("R5", 32'hFFFF8000, 5'd5, 1'b1);
    // R6 high immediate bit not sign-extended for OR
    apply(32'h3427FFFF, 32'h0, 32'h0);
    expectAll("R6", 32'h0000FFFF, 5'd7, 1'b1);
    // R7 result independent of opA
    apply(32'h3C680001, 32'hFFFFFFFF, 32'hFFFFFFFF);
    expectAll("R7", 32'h00010000, 5'd8, 1'b1);
    // R8 store opcode and unused function 0x3F
    apply(32'hAC220004, 32'h5, 32'h5);
    expectAll("R8", 32'h0, 5'd0, 1'b0);
    apply(32'h0022183F, 32'h5, 32'h5);
    expectAll("R8", 32'h0, 5'd0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule